// File: doc/BRIEF.md
# Hot-Plug Priority Port Selector

This block is the digital control for a display path that fans one source out to three sinks: two passive ports and one active port that carries a level-shifting re-driver. It watches the hot-plug-detect line of each sink, filters each line through a two-stage synchronizer and a stability counter, and then picks a single port. When one sink is present, that sink wins. When several are present, a three-level priority strap sets the order.

The chosen port sets every downstream enable. These are the passive port switches, the re-driver power, the sideband routing (AUX, passive DDC switch or DDC buffer), the equalization and pre-emphasis codes, the output termination and the squelch gate on the re-driver data outputs. A mode input chooses where the re-driver settings come from. In strap mode they come from input pins. In register mode they come from a small register file loaded through a one-cycle write strobe. All outputs are registered.

Top module: `hpd_port_selector`

## Requirements
- R1: While rst_n is low, and after it rises, every output is 0 until a filtered hot-plug input is high.
- R2: When exactly one filtered hot-plug input is high, that port is selected: sel_port is 1, 2 or 3 for hpd_in bit 0, 1 or 2, and the matching enable (p1_en, p2_en or p3_en) is high.
- R3: When more than one filtered hot-plug input is high, prio_code sets the order. 00 gives port1, port2, port3. 01 gives port1, port3, port2. 10 gives port3, port1, port2. 11 behaves as 10.
- R4: With no filtered hot-plug input high, sel_port is 0 and every enable output is low.
- R5: A change on hpd_in reaches the selection only after the synchronized value has held for the debounce limit, which is register address 3 (all DW bits, reset value DEB_RESET). A pulse shorter than the limit changes nothing.
- R6: With port1 or port2 selected, its cable-detect bit (cab_det bit 0 or 1) set to 0 raises aux_en, and set to 1 raises ddc_sw_en. In both cases p3_en, ddc_buf_en, term_50 and data_oe are low, and eq_code and pe_code are 0.
- R7: With port3 selected, p3_en is high and aux_en is low. In strap mode (mode_reg=0) the DDC buffer is used (ddc_buf_en=1). In register mode, bit 1 of address 2 set to 1 selects the passive switch (ddc_sw_en=1), and set to 0 selects the buffer.
- R8: In strap mode with port3 selected, eq_code is pin_eq and pe_code is pin_pe, each limited to 2 (3 reads as 2). Register writes have no effect on them. With port3 not selected, both codes are 0.
- R9: In register mode with port3 selected, eq_code is address 0 bits [2:0] (8 levels) and pe_code is address 1 bits [2:0] limited to 4 (5 levels).
- R10: With port3 selected, term_50 (1 = internal 50-ohm pull-up, 0 = open drain) follows pin_term in strap mode and address 2 bit 0 in register mode.
- R11: data_oe is high only when port3 is selected and clk_active is high. It drops when clk_active falls and returns when clk_active rises.
- R12: oe_n high drives every enable output, data_oe and sel_port to 0 on the next clock edge.
- R13: At most one of p1_en, p2_en and p3_en is high, and at most one of aux_en, ddc_sw_en and ddc_buf_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_reg | input | 1 | 0 = strap mode, 1 = register mode |
| oe_n | input | 1 | High forces all ports off |
| hpd_in | input | 3 | Asynchronous hot-plug detect, bit n = port n+1 |
| prio_code | input | 2 | Priority strap: 00 low, 01 high, 10/11 floating |
| cab_det | input | 2 | Cable detect for port1 (bit 0) and port2 (bit 1) |
| clk_active | input | 1 | Re-driver input clock activity qualifier |
| pin_eq | input | 2 | Strap equalization setting |
| pin_pe | input | 2 | Strap pre-emphasis setting |
| pin_term | input | 1 | Strap termination select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Register write data |
| sel_port | output | 2 | Selected port, 0 = none |
| p1_en | output | 1 | Passive port1 switch enable |
| p2_en | output | 1 | Passive port2 switch enable |
| p3_en | output | 1 | Re-driver / level shifter enable |
| aux_en | output | 1 | AUX path enable |
| ddc_sw_en | output | 1 | Passive DDC switch enable |
| ddc_buf_en | output | 1 | Bidirectional DDC buffer enable |
| data_oe | output | 1 | Re-driver data output enable (squelch gate) |
| term_50 | output | 1 | 1 = 50-ohm pull-up, 0 = open drain |
| eq_code | output | 3 | Equalization code |
| pe_code | output | 3 | Pre-emphasis code |

## Verification
The properties assume that mode_reg, cab_det, the straps and clk_active are level signals that already belong to the clock domain, since only hpd_in is synchronized. The implication on oe_n assumes the input is sampled at the clock edge, with no synchronizer in its path. The bench changes every input at the falling clock edge. After each hot-plug change it holds the inputs for longer than the programmed debounce limit before it compares the outputs. The one exception is a deliberately short pulse, which checks that the filter rejects it.

// File: rtl/hpsel_pkg.sv
package hpsel_pkg;
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_1    = 2'd1,
    PORT_2    = 2'd2,
    PORT_3    = 2'd3
  } port_e;

  localparam logic [1:0] ADDR_EQ  = 2'd0;
  localparam logic [1:0] ADDR_PE  = 2'd1;
  localparam logic [1:0] ADDR_OUT = 2'd2;
  localparam logic [1:0] ADDR_DEB = 2'd3;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] PIN_CODE_MAX = 3'd2;
  localparam logic [CODE_W-1:0] PE_REG_MAX   = 3'd4;

  typedef struct packed {
    port_e             sel;
    logic              p1;
    logic              p2;
    logic              p3;
    logic              aux;
    logic              ddc_sw;
    logic              ddc_buf;
    logic              data_oe;
    logic              term50;
    logic [CODE_W-1:0] eq;
    logic [CODE_W-1:0] pe;
  } ctl_out_t;

  function automatic logic [CODE_W-1:0] clamp_code(input logic [CODE_W-1:0] v,
                                                   input logic [CODE_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction
endpackage

// File: rtl/hpsel_debounce.sv
module hpsel_debounce #(
  parameter int N     = 3,
  parameter int DEB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     hpd_async,
  input  logic [DEB_W-1:0] limit,
  output logic [N-1:0]     hpd_stable
);
  logic [N-1:0]     s1_q, s2_q;
  logic [N-1:0]     cand_q, cand_d;
  logic [N-1:0]     stab_q, stab_d;
  logic [DEB_W-1:0] cnt_q, cnt_d;

  for (genvar g = 0; g < N; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= hpd_async[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  always_comb begin
    cand_d = cand_q;
    cnt_d  = cnt_q;
    stab_d = stab_q;
    if (s2_q != cand_q) begin
      cand_d = s2_q;
      cnt_d  = '0;
    end else if (cnt_q < limit) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      stab_d = cand_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      cnt_q  <= '0;
      stab_q <= '0;
    end else begin
      cand_q <= cand_d;
      cnt_q  <= cnt_d;
      stab_q <= stab_d;
    end
  end

  assign hpd_stable = stab_q;
endmodule

// File: rtl/hpsel_arbiter.sv
module hpsel_arbiter
  import hpsel_pkg::*;
(
  input  logic [2:0] hpd,
  input  logic [1:0] prio_code,
  output port_e      sel
);
  always_comb begin
    sel = PORT_NONE;
    unique case (prio_code)
      2'b00: begin
        if      (hpd[0]) sel = PORT_1;
        else if (hpd[1]) sel = PORT_2;
        else if (hpd[2]) sel = PORT_3;
      end
      2'b01: begin
        if      (hpd[0]) sel = PORT_1;
        else if (hpd[2]) sel = PORT_3;
        else if (hpd[1]) sel = PORT_2;
      end
      default: begin
        if      (hpd[2]) sel = PORT_3;
        else if (hpd[0]) sel = PORT_1;
        else if (hpd[1]) sel = PORT_2;
      end
    endcase
  end
endmodule

// File: rtl/hpsel_cfg.sv
module hpsel_cfg
  import hpsel_pkg::*;
#(
  parameter int               DW        = 8,
  parameter int               DEB_W     = 8,
  parameter logic [DEB_W-1:0] DEB_RESET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              mode_reg,
  input  logic [1:0]        pin_eq,
  input  logic [1:0]        pin_pe,
  input  logic              pin_term,
  output logic [CODE_W-1:0] eq_sel,
  output logic [CODE_W-1:0] pe_sel,
  output logic              term_sel,
  output logic              ddc_buf_sel,
  output logic [DEB_W-1:0]  deb_limit
);
  logic [CODE_W-1:0] eq_q, eq_d, pe_q, pe_d;
  logic              term_q, term_d, pass_q, pass_d;
  logic [DEB_W-1:0]  deb_q, deb_d;

  always_comb begin
    eq_d   = eq_q;
    pe_d   = pe_q;
    term_d = term_q;
    pass_d = pass_q;
    deb_d  = deb_q;
    if (wr_en) begin
      unique case (wr_addr)
        ADDR_EQ:  eq_d = wr_data[CODE_W-1:0];
        ADDR_PE:  pe_d = clamp_code(wr_data[CODE_W-1:0], PE_REG_MAX);
        ADDR_OUT: begin
          term_d = wr_data[0];
          pass_d = wr_data[1];
        end
        default:  deb_d = wr_data[DEB_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q   <= '0;
      pe_q   <= '0;
      term_q <= 1'b0;
      pass_q <= 1'b0;
      deb_q  <= DEB_RESET;
    end else begin
      eq_q   <= eq_d;
      pe_q   <= pe_d;
      term_q <= term_d;
      pass_q <= pass_d;
      deb_q  <= deb_d;
    end
  end

  always_comb begin
    if (mode_reg) begin
      eq_sel      = eq_q;
      pe_sel      = pe_q;
      term_sel    = term_q;
      ddc_buf_sel = !pass_q;
    end else begin
      eq_sel      = clamp_code({1'b0, pin_eq}, PIN_CODE_MAX);
      pe_sel      = clamp_code({1'b0, pin_pe}, PIN_CODE_MAX);
      term_sel    = pin_term;
      ddc_buf_sel = 1'b1;
    end
  end

  assign deb_limit = deb_q;
endmodule

// File: rtl/hpd_port_selector.sv
module hpd_port_selector
  import hpsel_pkg::*;
#(
  parameter int               DW        = 8,
  parameter int               DEB_W     = 8,
  parameter logic [DEB_W-1:0] DEB_RESET = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_reg,
  input  logic          oe_n,
  input  logic [2:0]    hpd_in,
  input  logic [1:0]    prio_code,
  input  logic [1:0]    cab_det,
  input  logic          clk_active,
  input  logic [1:0]    pin_eq,
  input  logic [1:0]    pin_pe,
  input  logic          pin_term,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [1:0]    sel_port,
  output logic          p1_en,
  output logic          p2_en,
  output logic          p3_en,
  output logic          aux_en,
  output logic          ddc_sw_en,
  output logic          ddc_buf_en,
  output logic          data_oe,
  output logic          term_50,
  output logic [2:0]    eq_code,
  output logic [2:0]    pe_code
);
  logic [2:0]        hpd_f;
  logic [DEB_W-1:0]  deb_limit;
  port_e             sel;
  logic [CODE_W-1:0] eq_sel, pe_sel;
  logic              term_sel, ddc_buf_sel;
  ctl_out_t          out_d, out_q;

  hpsel_debounce #(.N(3), .DEB_W(DEB_W)) u_deb (
    .clk(clk), .rst_n(rst_n), .hpd_async(hpd_in),
    .limit(deb_limit), .hpd_stable(hpd_f)
  );

  hpsel_arbiter u_arb (.hpd(hpd_f), .prio_code(prio_code), .sel(sel));

  hpsel_cfg #(.DW(DW), .DEB_W(DEB_W), .DEB_RESET(DEB_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_reg(mode_reg), .pin_eq(pin_eq),
    .pin_pe(pin_pe), .pin_term(pin_term), .eq_sel(eq_sel),
    .pe_sel(pe_sel), .term_sel(term_sel), .ddc_buf_sel(ddc_buf_sel),
    .deb_limit(deb_limit)
  );

  always_comb begin
    out_d = '0;
    if (!oe_n) begin
      out_d.sel = sel;
      unique case (sel)
        PORT_1: begin
          out_d.p1     = 1'b1;
          out_d.aux    = !cab_det[0];
          out_d.ddc_sw = cab_det[0];
        end
        PORT_2: begin
          out_d.p2     = 1'b1;
          out_d.aux    = !cab_det[1];
          out_d.ddc_sw = cab_det[1];
        end
        PORT_3: begin
          out_d.p3      = 1'b1;
          out_d.ddc_buf = ddc_buf_sel;
          out_d.ddc_sw  = !ddc_buf_sel;
          out_d.eq      = eq_sel;
          out_d.pe      = pe_sel;
          out_d.term50  = term_sel;
          out_d.data_oe = clk_active;
        end
        default: out_d.sel = PORT_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign sel_port   = out_q.sel;
  assign p1_en      = out_q.p1;
  assign p2_en      = out_q.p2;
  assign p3_en      = out_q.p3;
  assign aux_en     = out_q.aux;
  assign ddc_sw_en  = out_q.ddc_sw;
  assign ddc_buf_en = out_q.ddc_buf;
  assign data_oe    = out_q.data_oe;
  assign term_50    = out_q.term50;
  assign eq_code    = out_q.eq;
  assign pe_code    = out_q.pe;
endmodule

// File: rtl/hpsel_checker.sv
module hpsel_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_reg,
  input logic       oe_n,
  input logic [1:0] sel_port,
  input logic       p1_en,
  input logic       p2_en,
  input logic       p3_en,
  input logic       aux_en,
  input logic       ddc_sw_en,
  input logic       ddc_buf_en,
  input logic       data_oe,
  input logic       term_50,
  input logic [2:0] eq_code,
  input logic [2:0] pe_code
);
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p1_en, p2_en, p3_en})); // R13
  AST_ONE_SIDEBAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aux_en, ddc_sw_en, ddc_buf_en})); // R13
  AST_OEB_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> !(p1_en || p2_en || p3_en || data_oe || aux_en || ddc_sw_en || ddc_buf_en)); // R12
  AST_SQUELCH_NEEDS_P3: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> p3_en); // R11
  AST_PASSIVE_NO_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_en || p2_en) |-> (!ddc_buf_en && !term_50 && eq_code == 3'd0 && pe_code == 3'd0)); // R6
  AST_PIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_reg |=> (eq_code <= 3'd2 && pe_code <= 3'd2)); // R8
  AST_PE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pe_code <= 3'd4); // R9
  AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_port == 2'd0) |-> !(p1_en || p2_en || p3_en || aux_en || ddc_sw_en || ddc_buf_en)); // R4
  AST_P3_SEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    p3_en |-> (sel_port == 2'd3 && !aux_en)); // R7
endmodule

bind hpd_port_selector hpsel_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .oe_n(oe_n),
  .sel_port(sel_port), .p1_en(p1_en), .p2_en(p2_en), .p3_en(p3_en),
  .aux_en(aux_en), .ddc_sw_en(ddc_sw_en), .ddc_buf_en(ddc_buf_en),
  .data_oe(data_oe), .term_50(term_50), .eq_code(eq_code), .pe_code(pe_code)
);

// File: tb/sim_hpd_port_selector.sv
module sim_hpd_port_selector;
  localparam int CLK_P = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_reg, oe_n, clk_active, pin_term, wr_en;
  logic [2:0] hpd_in;
  logic [1:0] prio_code, cab_det, pin_eq, pin_pe, wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0] sel_port;
  logic p1_en, p2_en, p3_en, aux_en, ddc_sw_en, ddc_buf_en, data_oe, term_50;
  logic [2:0] eq_code, pe_code;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [2:0] sh_eq, sh_pe;
  logic sh_term, sh_pass;
  int sh_deb;

  always #(CLK_P/2) clk = ~clk;

  hpd_port_selector #(.DW(DW), .DEB_W(8), .DEB_RESET(8'd16)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_reg(mode_reg), .oe_n(oe_n),
    .hpd_in(hpd_in), .prio_code(prio_code), .cab_det(cab_det),
    .clk_active(clk_active), .pin_eq(pin_eq), .pin_pe(pin_pe),
    .pin_term(pin_term), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_port(sel_port), .p1_en(p1_en), .p2_en(p2_en), .p3_en(p3_en),
    .aux_en(aux_en), .ddc_sw_en(ddc_sw_en), .ddc_buf_en(ddc_buf_en),
    .data_oe(data_oe), .term_50(term_50), .eq_code(eq_code), .pe_code(pe_code)
  );

  function automatic logic [2:0] lim(input logic [2:0] v, input logic [2:0] m);
    return (v > m) ? m : v;
  endfunction

  // Packed: {sel[1:0], p1, p2, p3, aux, ddc_sw, ddc_buf, data_oe, term, eq[2:0], pe[2:0]}
  function automatic logic [15:0] model();
    logic [1:0] s;
    logic [15:0] r;
    s = 2'd0;
    if (prio_code == 2'b00) begin
      if (hpd_in[0]) s = 2'd1; else if (hpd_in[1]) s = 2'd2; else if (hpd_in[2]) s = 2'd3;
    end else if (prio_code == 2'b01) begin
      if (hpd_in[0]) s = 2'd1; else if (hpd_in[2]) s = 2'd3; else if (hpd_in[1]) s = 2'd2;
    end else begin
      if (hpd_in[2]) s = 2'd3; else if (hpd_in[0]) s = 2'd1; else if (hpd_in[1]) s = 2'd2;
    end
    r = '0;
    if (oe_n) return r;
    r[15:14] = s;
    case (s)
      2'd1: begin r[13] = 1'b1; r[10] = !cab_det[0]; r[9] = cab_det[0]; end
      2'd2: begin r[12] = 1'b1; r[10] = !cab_det[1]; r[9] = cab_det[1]; end
      2'd3: begin
        r[11] = 1'b1;
        r[7] = clk_active;
        if (mode_reg) begin
          r[8] = !sh_pass; r[9] = sh_pass; r[6] = sh_term;
          r[5:3] = sh_eq; r[2:0] = sh_pe;
        end else begin
          r[8] = 1'b1; r[6] = pin_term;
          r[5:3] = lim({1'b0, pin_eq}, 3'd2); r[2:0] = lim({1'b0, pin_pe}, 3'd2);
        end
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] actual();
    return {sel_port, p1_en, p2_en, p3_en, aux_en, ddc_sw_en, ddc_buf_en,
            data_oe, term_50, eq_code, pe_code};
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (actual() !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
    case (a)
      2'd0: sh_eq = d[2:0];
      2'd1: sh_pe = lim(d[2:0], 3'd4);
      2'd2: begin sh_term = d[0]; sh_pass = d[1]; end
      default: sh_deb = int'(d);
    endcase
  endtask

  task automatic settle();
    cyc(sh_deb + 8);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_reg = 1'b0; oe_n = 1'b0; hpd_in = '0; prio_code = '0;
    cab_det = '0; clk_active = 1'b1; pin_eq = '0; pin_pe = '0; pin_term = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    sh_eq = '0; sh_pe = '0; sh_term = 1'b0; sh_pass = 1'b0; sh_deb = 16;
    cyc(3);
    check("R1 in reset", 16'h0);
    rst_n = 1'b1;
    cyc(3);
    check("R1 after reset", 16'h0);

    wr(2'd3, 8'd4);
    hpd_in = 3'b001; settle(); check("R2 port1 alone", model());
    check("R6 aux on port1", {2'd1, 8'b1001_0000, 6'd0});
    cab_det = 2'b01; cyc(2); check("R6 ddc on port1", {2'd1, 8'b1000_1000, 6'd0});
    hpd_in = 3'b010; cab_det = 2'b00; settle(); check("R2 port2 alone", model());
    hpd_in = 3'b100; pin_eq = 2'd3; pin_pe = 2'd1; pin_term = 1'b1; settle();
    check("R8 strap clamp", {2'd3, 8'b0010_0111, 3'd2, 3'd1});
    check("R10 strap term", model());
    clk_active = 1'b0; cyc(2); check("R11 squelch off", {2'd3, 8'b0010_0101, 3'd2, 3'd1});
    clk_active = 1'b1; cyc(2); check("R11 squelch resume", model());

    hpd_in = 3'b111;
    prio_code = 2'b00; settle(); check("R3 code00", {2'd1, 8'b1001_0000, 6'd0});
    prio_code = 2'b01; hpd_in = 3'b110; settle(); check("R3 code01", {2'd3, 8'b0010_0111, 3'd2, 3'd1});
    hpd_in = 3'b111; prio_code = 2'b10; settle(); check("R3 code10", model());
    prio_code = 2'b11; cyc(2); check("R3 code11", {2'd3, 8'b0010_0111, 3'd2, 3'd1});
    prio_code = 2'b00; hpd_in = 3'b110; settle(); check("R3 code00 p2 over p3", model());

    hpd_in = 3'b000; settle(); check("R4 none", 16'h0);
    hpd_in = 3'b010; cyc(2); hpd_in = 3'b000; cyc(20); check("R5 short pulse", 16'h0);
    hpd_in = 3'b100; cyc(3); check("R5 not yet", 16'h0);
    settle(); check("R5 held", model());

    wr(2'd0, 8'd6); wr(2'd1, 8'd7); wr(2'd2, 8'd3);
    cyc(2); check("R8 regs ignored in strap mode", {2'd3, 8'b0010_0111, 3'd2, 3'd1});
    mode_reg = 1'b1; cyc(2);
    check("R9 reg eq/pe", {2'd3, 8'b0010_1011, 3'd6, 3'd4});
    check("R7 passive ddc", model());
    wr(2'd2, 8'd0); cyc(2); check("R10 reg term open", {2'd3, 8'b0010_0110, 3'd6, 3'd4});
    check("R7 buffer ddc", model());
    oe_n = 1'b1; cyc(2); check("R12 oe_n off", 16'h0);
    oe_n = 1'b0; cyc(2); check("R12 oe_n release", model());

    for (int i = 0; i < 300; i++) begin
      hpd_in = 3'($urandom_range(0, 7));
      prio_code = 2'($urandom_range(0, 3));
      cab_det = 2'($urandom_range(0, 3));
      mode_reg = 1'($urandom_range(0, 1));
      oe_n = ($urandom_range(0, 9) == 0);
      clk_active = ($urandom_range(0, 3) != 0);
      pin_eq = 2'($urandom_range(0, 3));
      pin_pe = 2'($urandom_range(0, 3));
      pin_term = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) wr(2'($urandom_range(0, 2)), 8'($urandom_range(0, 255)));
      settle();
      check("R13 random R2 R3", model());
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
  end
endmodule